// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block derives the bit clock and the frame-start strobe for a serial PCM audio port from one of two incoming clock-enable pulses. A select control picks either the auxiliary enable or the high-speed (48 MHz derived) enable. Every qualifying pulse advances an 8-bit bit-clock prescaler, which divides the selected rate by (bit divisor + 1). Each bit tick in turn advances a frame prescaler, which divides the bit rate by (frame divisor + 1).

The frame prescaler always runs, including when the port's frame sync comes from outside, so the frame divisor must always hold a correct value. As an example, an 8 kHz frame needs a bit clock of at most 1024 kHz. All three control fields load together through a single write strobe and are zero after reset. Both stages therefore divide by one and the auxiliary source is selected.

A two-state sequencer handles source changes. In ST_RUN, ticks are counted. A write that changes the select bit clears both counters and the bit-clock level, and moves to ST_SWITCH. ST_SWITCH ignores ticks for one cycle and then returns to ST_RUN. Any cycle without a select change leads to ST_RUN.

Top module: `audio_clkgen`

## Requirements
- R1: After reset, all outputs are low and the configuration is zero: auxiliary source, divide-by-1 on both stages. Each auxiliary pulse then yields a bit edge that is also a frame start.
- R2: When select is 0, only `src_aux_en` pulses advance the bit prescaler. When select is 1, only `src_hs_en` pulses advance it. The other enable has no effect on any output.
- R3: `bit_edge_o` pulses high for one cycle, in the cycle after a selected pulse is sampled. This happens on the 1st, (B+2)th, (2B+3)th … selected pulse counted from reset or from a source switch, where B is the bit divisor.
- R4: `bclk_o` inverts exactly in the cycles where `bit_edge_o` is high. It changes at no other time, except that a source switch drives it low.
- R5: `frame_start_o` is high only together with `bit_edge_o`. It marks the 1st, (F+2)th … bit edge counted from reset or from a source switch, where F is the frame divisor.
- R6: A new bit or frame divisor does not disturb a count already in progress. It is loaded at that stage's next terminal count.
- R7: A write that changes the select bit clears both counters and drives `bclk_o` low. Selected pulses in the write cycle and in the following cycle (ST_SWITCH) are ignored.
- R8: A write that leaves the select bit unchanged does not restart either counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_aux_en | input | 1 | Auxiliary source clock-enable pulse |
| src_hs_en | input | 1 | High-speed (48 MHz) source clock-enable pulse |
| cfg_we | input | 1 | Write strobe for all control fields |
| cfg_src_sel | input | 1 | Source select: 0 auxiliary, 1 high-speed |
| cfg_bit_div | input | BIT_W | Bit prescaler divisor minus one |
| cfg_frm_div | input | FRM_W | Frame prescaler divisor minus one |
| bclk_o | output | 1 | Bit-clock level |
| bit_edge_o | output | 1 | One-cycle strobe at each bit-clock transition |
| frame_start_o | output | 1 | One-cycle strobe at the bit edge that starts a frame |

## Verification
The bench targets several corner cases, each with a distinct failure signature:
- A divisor rewritten mid-count. A design that reloads at once instead of at terminal count shortens the current period.
- A write with an unchanged select. A design that restarts the counters on every write shifts the frame phase.
- A select change with pulses in the write cycle and in the guard cycle. A design that drops the guard cycle emits an early, partial bit edge.
- The maximum bit divisor of 255 on the high-speed source. A prescaler that is one bit short wraps and produces edges far too often.
- Pulses on the unselected enable. These expose a swapped or ORed source multiplexer.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;

    typedef enum logic [0:0] {
        ST_RUN    = 1'b0,
        ST_SWITCH = 1'b1
    } seq_state_t;

endpackage

// File: rtl/audio_clkgen_cfg.sv
module audio_clkgen_cfg #(
    parameter int BIT_W = 8,
    parameter int FRM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             sel_in,
    input  logic [BIT_W-1:0] bdiv_in,
    input  logic [FRM_W-1:0] fdiv_in,
    output logic             sel_q,
    output logic [BIT_W-1:0] bdiv_q,
    output logic [FRM_W-1:0] fdiv_q,
    output logic             sel_change
);

    always_comb sel_change = we && (sel_in != sel_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            bdiv_q <= '0;
            fdiv_q <= '0;
        end else if (we) begin
            sel_q  <= sel_in;
            bdiv_q <= bdiv_in;
            fdiv_q <= fdiv_in;
        end
    end

endmodule

// File: rtl/audio_clkgen_seq.sv
module audio_clkgen_seq
    import audio_clkgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_change,
    output seq_state_t state,
    output logic       count_en,
    output logic       clr
);

    seq_state_t state_nx;

    always_comb begin
        unique case (state)
            ST_RUN:    state_nx = sel_change ? ST_SWITCH : ST_RUN;
            ST_SWITCH: state_nx = sel_change ? ST_SWITCH : ST_RUN;
            default:   state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // Output decode: counting only in ST_RUN outside a select-change write.
    always_comb begin
        clr = sel_change;
        unique case (state)
            ST_RUN:    count_en = !sel_change;
            ST_SWITCH: count_en = 1'b0;
            default:   count_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/audio_clkgen_presc.sv
module audio_clkgen_presc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] reload,
    output logic         tick
);

    localparam logic [W-1:0] CNT_ZERO = '0;

    logic [W-1:0] cnt;

    always_comb tick = adv && (cnt == CNT_ZERO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= CNT_ZERO;
        end else if (clr) begin
            cnt <= CNT_ZERO;
        end else if (adv) begin
            if (cnt == CNT_ZERO) cnt <= reload;
            else                 cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
    import audio_clkgen_pkg::*;
#(
    parameter int BIT_W = 8,
    parameter int FRM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_aux_en,
    input  logic             src_hs_en,
    input  logic             cfg_we,
    input  logic             cfg_src_sel,
    input  logic [BIT_W-1:0] cfg_bit_div,
    input  logic [FRM_W-1:0] cfg_frm_div,
    output logic             bclk_o,
    output logic             bit_edge_o,
    output logic             frame_start_o
);

    logic             sel_q;
    logic [BIT_W-1:0] bdiv_q;
    logic [FRM_W-1:0] fdiv_q;
    logic             sel_change;
    seq_state_t       seq_state;
    logic             count_en;
    logic             clr;
    logic             src_tick;
    logic             bit_tick;
    logic             frm_tick;
    logic             bclk_q;
    logic             edge_q;
    logic             frame_q;

    audio_clkgen_cfg #(.BIT_W(BIT_W), .FRM_W(FRM_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .sel_in     (cfg_src_sel),
        .bdiv_in    (cfg_bit_div),
        .fdiv_in    (cfg_frm_div),
        .sel_q      (sel_q),
        .bdiv_q     (bdiv_q),
        .fdiv_q     (fdiv_q),
        .sel_change (sel_change)
    );

    audio_clkgen_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_change (sel_change),
        .state      (seq_state),
        .count_en   (count_en),
        .clr        (clr)
    );

    always_comb src_tick = (sel_q ? src_hs_en : src_aux_en) && count_en;

    audio_clkgen_presc #(.W(BIT_W)) u_bit_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .adv    (src_tick),
        .reload (bdiv_q),
        .tick   (bit_tick)
    );

    audio_clkgen_presc #(.W(FRM_W)) u_frm_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .adv    (bit_tick),
        .reload (fdiv_q),
        .tick   (frm_tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q  <= 1'b0;
            edge_q  <= 1'b0;
            frame_q <= 1'b0;
        end else if (clr) begin
            bclk_q  <= 1'b0;
            edge_q  <= 1'b0;
            frame_q <= 1'b0;
        end else begin
            edge_q  <= bit_tick;
            frame_q <= frm_tick;
            if (bit_tick) bclk_q <= ~bclk_q;
        end
    end

    assign bclk_o        = bclk_q;
    assign bit_edge_o    = edge_q;
    assign frame_start_o = frame_q;

endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk
    import audio_clkgen_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       src_aux_en,
    input logic       src_hs_en,
    input logic       cfg_we,
    input logic       cfg_src_sel,
    input logic       sel_q,
    input seq_state_t state,
    input logic       bclk_o,
    input logic       bit_edge_o,
    input logic       frame_start_o
);

    p_frame_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> bit_edge_o);

    p_bclk_flips_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_edge_o |-> (bclk_o != $past(bclk_o)));

    p_bclk_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_edge_o && !$past(cfg_we && (cfg_src_sel != sel_q))) |-> $stable(bclk_o));

    p_src_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_edge_o |-> $past(sel_q ? src_hs_en : src_aux_en));

    p_switch_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_we && (cfg_src_sel != sel_q)) |-> (!bit_edge_o && !bclk_o && !frame_start_o));

    p_guard_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWITCH) |=> !bit_edge_o);

endmodule

bind audio_clkgen audio_clkgen_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_aux_en    (src_aux_en),
    .src_hs_en     (src_hs_en),
    .cfg_we        (cfg_we),
    .cfg_src_sel   (cfg_src_sel),
    .sel_q         (sel_q),
    .state         (seq_state),
    .bclk_o        (bclk_o),
    .bit_edge_o    (bit_edge_o),
    .frame_start_o (frame_start_o)
);

// File: tb/tb_audio_clkgen.sv
`timescale 1ns/1ps
module tb_audio_clkgen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_aux_en = 1'b0;
    logic       src_hs_en = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_src_sel = 1'b0;
    logic [7:0] cfg_bit_div = '0;
    logic [7:0] cfg_frm_div = '0;
    logic       bclk_o;
    logic       bit_edge_o;
    logic       frame_start_o;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model state
    logic       m_sel = 1'b0;
    logic [7:0] m_bdiv = '0, m_fdiv = '0, m_bcnt = '0, m_fcnt = '0;
    logic       m_bclk = 1'b0, m_sw = 1'b0;
    int         edge_cnt = 0;

    always #10 clk = ~clk;

    audio_clkgen dut (
        .clk(clk), .rst_n(rst_n), .src_aux_en(src_aux_en), .src_hs_en(src_hs_en),
        .cfg_we(cfg_we), .cfg_src_sel(cfg_src_sel), .cfg_bit_div(cfg_bit_div),
        .cfg_frm_div(cfg_frm_div), .bclk_o(bclk_o), .bit_edge_o(bit_edge_o),
        .frame_start_o(frame_start_o)
    );

    function automatic logic [7:0] next_cnt(input logic [7:0] cnt, input logic [7:0] rl);
        return (cnt == 8'd0) ? rl : cnt - 8'd1;
    endfunction

    task automatic check3(input string tag, input logic e_edge, input logic e_frm, input logic e_bclk);
        vectors++;
        if (bit_edge_o !== e_edge || frame_start_o !== e_frm || bclk_o !== e_bclk) begin
            fails++;
            $display("FAIL %s t=%0t edge/frame/bclk actual=%b%b%b expected=%b%b%b",
                     tag, $time, bit_edge_o, frame_start_o, bclk_o, e_edge, e_frm, e_bclk);
        end
    endtask

    // one cycle: drive at negedge, predict, sample at next negedge
    task automatic step(input logic aux, input logic hs, input logic we, input logic sel,
                        input logic [7:0] b, input logic [7:0] f, input string tag);
        logic resync, tick, e_edge, e_frm;
        src_aux_en = aux; src_hs_en = hs; cfg_we = we;
        cfg_src_sel = sel; cfg_bit_div = b; cfg_frm_div = f;
        resync = we && (sel != m_sel);
        tick   = (m_sel ? hs : aux) && !resync && !m_sw;
        e_edge = tick && (m_bcnt == 8'd0);
        e_frm  = e_edge && (m_fcnt == 8'd0);
        if (resync) begin
            m_bcnt = '0; m_fcnt = '0; m_bclk = 1'b0;
        end else if (tick) begin
            m_bcnt = next_cnt(m_bcnt, m_bdiv);
            if (e_edge) begin
                m_fcnt = next_cnt(m_fcnt, m_fdiv);
                m_bclk = ~m_bclk;
            end
        end
        m_sw = resync;
        if (we) begin m_sel = sel; m_bdiv = b; m_fdiv = f; end
        if (e_edge) edge_cnt++;
        @(posedge clk);
        @(negedge clk);
        check3(tag, e_edge, e_frm, m_bclk);
    endtask

    task automatic idle_run(input int n, input int pa, input int ph, input string tag);
        for (int i = 0; i < n; i++)
            step(($urandom % 100) < pa, ($urandom % 100) < ph, 1'b0, m_sel, m_bdiv, m_fdiv, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int dummy;
        int e0;
        dummy = $urandom(32'h5eed_a0d1);
        repeat (3) @(negedge clk);
        check3("R1 reset", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check3("R1 after release", 1'b0, 1'b0, 1'b0);

        // R1: zero config, every aux pulse is an edge and a frame start
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0, "R1 div1");
        // R2: hs pulses ignored with aux selected
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 8'd0, 8'd0, "R2 hs ignored");

        // R3 R4 R5: random divisors, aux source
        for (int k = 0; k < 12; k++) begin
            step(1'b0, 1'b0, 1'b1, 1'b0, 8'($urandom % 6), 8'($urandom % 5), "R8 same-sel write");
            idle_run(150, 60, 50, "R3 R4 R5 aux random");
        end

        // R6: mid-count divisor change
        step(1'b0, 1'b0, 1'b1, 1'b0, 8'd7, 8'd3, "R6 setup");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0, m_bdiv, m_fdiv, "R6 pre");
        step(1'b1, 1'b0, 1'b1, 1'b0, 8'd1, 8'd0, "R6 rewrite");
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, 1'b0, m_bdiv, m_fdiv, "R6 post");

        // R7: switch to hs with pulses in write and guard cycles
        step(1'b1, 1'b1, 1'b1, 1'b1, 8'd2, 8'd1, "R7 switch write");
        step(1'b1, 1'b1, 1'b0, 1'b1, 8'd2, 8'd1, "R7 guard");
        for (int i = 0; i < 12; i++) step(1'b0, 1'b1, 1'b0, 1'b1, m_bdiv, m_fdiv, "R7 restart");
        // R2: aux ignored with hs selected
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b0, 1'b1, m_bdiv, m_fdiv, "R2 aux ignored");

        // R3 boundary: maximum bit divisor
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'd255, 8'd0, "R3 max setup");
        e0 = edge_cnt;
        for (int i = 0; i < 600; i++) step(1'b0, 1'b1, 1'b0, 1'b1, m_bdiv, m_fdiv, "R3 div256");
        vectors++;
        if (edge_cnt - e0 != 3) begin
            fails++;
            $display("FAIL R3 div256 edge count actual=%0d expected=3", edge_cnt - e0);
        end

        // R8: rewrite with unchanged select mid-count
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'd4, 8'd2, "R8 setup");
        for (int i = 0; i < 2; i++) step(1'b0, 1'b1, 1'b0, 1'b1, m_bdiv, m_fdiv, "R8 pre");
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'd4, 8'd2, "R8 same-sel rewrite");
        for (int i = 0; i < 30; i++) step(1'b0, 1'b1, 1'b0, 1'b1, m_bdiv, m_fdiv, "R8 post");

        // random mix with occasional writes and switches
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 40) == 0)
                step(($urandom % 2) == 1, ($urandom % 2) == 1, 1'b1, ($urandom % 2) == 1,
                     8'($urandom % 5), 8'($urandom % 4), "R6 R7 R8 random write");
            else
                step(($urandom % 100) < 50, ($urandom % 100) < 50, 1'b0, m_sel, m_bdiv, m_fdiv,
                     "R2 R3 R5 random run");
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule